// File: doc/BRIEF.md
# Transmit Queue Scheduler Control Register Bank

This block holds the software-visible configuration and progress state for a transmit scheduler that serves 16 queues. Software reaches it through a 32-bit word-addressed register port. Through that port it sets per-queue empty flags, chain-mode selects, interrupt enables, 8-bit write and read pointers, and a per-queue status word. It also sets an 8-bit channel enable word for the DMA/FIFO channels. The scheduler core sits outside this block. It reports each read-pointer advance on a one-bit-per-queue increment port.

Two of the register groups take masked writes. In the empty-flag register, the upper half of the data word is a per-bit write mask for the lower half. In each queue status word, data bits 19..10 enable bits 9..0. A field changes only where its enable is set, so software can change one field without first reading the word back.

When the core advances the read pointer of a queue whose interrupt enable is set, a sticky pending bit is set for that queue. Software clears it by writing 1 to it. The OR of all pending bits drives the single interrupt output.

Top module: `sched_csr`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq` is 0.
- R2: At 0x00 the empty-flag register updates flag q (bits 15..0) from data bit q only when data bit 16+q is 1. Flags whose mask bit is 0 keep their value.
- R3: At 0x04 the channel enable register stores data bits 7..0. Read bits 31..8 are zero.
- R4: At 0x08 the chain select register stores bits 15..0, one per queue, and at 0x0C the interrupt enable register does the same. In both, written bits 31..16 are dropped and read as zero.
- R5: The write pointer of queue q sits at 0x40+4q and stores data bits 7..0. Read bits 31..8 are zero, and writing it leaves every read pointer unchanged.
- R6: The read pointer of queue q sits at 0x80+4q and software can write it. A 1 on `sched_rp_inc[q]` adds 1 to it, modulo 256, at the next clock edge. Several queues may advance in the same cycle.
- R7: If a register write to read pointer q and `sched_rp_inc[q]` occur in the same cycle, the written value is stored, no increment happens, and no pending bit is set.
- R8: The status word of queue q sits at 0xC0+4q. Its fields are: bit 0 active, bits 4..1 FIFO number, bit 5 window-left, bit 8 scheduler-ACK mode, and bits 9, 7 and 6 spare. Bit i (0..9) changes only when data bit 10+i is 1. Reads return bits 9..0, and bits 31..10 read as zero.
- R9: An applied increment of queue q while interrupt enable bit q is 1 sets pending bit q. Pending bits are read at 0x10, bit q per queue. An increment with the enable at 0 sets nothing.
- R10: Writing 1 to bit q at 0x10 clears pending bit q, and writing 0 leaves it. If a set and a clear of the same bit fall in one cycle, the bit ends up set.
- R11: `irq` is 1 exactly while at least one pending bit is 1. It is visible in the cycle after the increment that set the bit.
- R12: Unmapped word addresses (0x14..0x3C) and any address with bits 1..0 non-zero read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Byte address of the register accessed |
| reg_wdata | input | 32 | Register write data, including embedded masks |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sched_rp_inc | input | 16 | Per-queue read-pointer increment from the scheduler core |
| irq | output | 1 | OR of all pending interrupt bits |

## Verification
The assertions assume that reset is held through at least one clock edge before any write or increment. They also assume that `reg_addr`, `reg_wen` and `sched_rp_inc` are stable around each rising edge. The bench drives all inputs on the falling edge and holds them for a full cycle, which keeps within those assumptions. The decode check takes for granted that one address selects at most one target, so the bench also issues misaligned and unmapped addresses. Collision cases are driven deliberately: a write and an increment to the same read pointer, and a pending clear together with a pending set.

// File: rtl/sched_csr_pkg.sv
package sched_csr_pkg;

    localparam int NQ        = 16;
    localparam int NCH       = 8;
    localparam int PTR_W     = 8;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int STAT_W    = 10;
    localparam int QIDX_W    = $clog2(NQ);
    localparam int EMASK_LSB = NQ;
    localparam int SEN_LSB   = STAT_W;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_EMPTY,
        RG_CHAN,
        RG_CHAIN,
        RG_IMASK,
        RG_IPEND,
        RG_WPTR,
        RG_RPTR,
        RG_STAT
    } region_e;

    typedef struct packed {
        region_e           rg;
        logic [QIDX_W-1:0] q;
    } dec_t;

    typedef struct packed {
        logic       spare9;
        logic       sack_mode;
        logic [1:0] spare7_6;
        logic       win_left;
        logic [3:0] fifo_num;
        logic       active;
    } qstat_t;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        qstat_t           stat;
        logic             pend;
    } qview_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.q  = a[QIDX_W+1:2];
        d.rg = RG_NONE;
        if (a[1:0] == 2'b00) begin
            case (a[ADDR_W-1:ADDR_W-2])
                2'b00: begin
                    case (a[5:2])
                        4'd0:    d.rg = RG_EMPTY;
                        4'd1:    d.rg = RG_CHAN;
                        4'd2:    d.rg = RG_CHAIN;
                        4'd3:    d.rg = RG_IMASK;
                        4'd4:    d.rg = RG_IPEND;
                        default: d.rg = RG_NONE;
                    endcase
                end
                2'b01:   d.rg = RG_WPTR;
                2'b10:   d.rg = RG_RPTR;
                default: d.rg = RG_STAT;
            endcase
        end
        return d;
    endfunction

    function automatic logic [STAT_W-1:0] merge_masked(
        input logic [STAT_W-1:0] old_v,
        input logic [STAT_W-1:0] new_v,
        input logic [STAT_W-1:0] en
    );
        return (old_v & ~en) | (new_v & en);
    endfunction

endpackage

// File: rtl/sched_csr_decode.sv
module sched_csr_decode
    import sched_csr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    output dec_t              dec,
    output logic              we_empty,
    output logic              we_chan,
    output logic              we_chain,
    output logic              we_imask,
    output logic              we_ipend,
    output logic [NQ-1:0]     we_wptr,
    output logic [NQ-1:0]     we_rptr,
    output logic [NQ-1:0]     we_stat
);

    always_comb begin
        dec      = decode_addr(addr);
        we_empty = wen && (dec.rg == RG_EMPTY);
        we_chan  = wen && (dec.rg == RG_CHAN);
        we_chain = wen && (dec.rg == RG_CHAIN);
        we_imask = wen && (dec.rg == RG_IMASK);
        we_ipend = wen && (dec.rg == RG_IPEND);
        we_wptr  = '0;
        we_rptr  = '0;
        we_stat  = '0;
        if (wen) begin
            case (dec.rg)
                RG_WPTR: we_wptr[dec.q] = 1'b1;
                RG_RPTR: we_rptr[dec.q] = 1'b1;
                RG_STAT: we_stat[dec.q] = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sched_csr_qslot.sv
module sched_csr_qslot
    import sched_csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we_wptr,
    input  logic                we_rptr,
    input  logic                we_stat,
    input  logic [PTR_W-1:0]    wd_ptr,
    input  logic [2*STAT_W-1:0] wd_stat,
    input  logic                inc,
    input  logic                imask,
    input  logic                clr_pend,
    output qview_t              view
);

    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    qstat_t           stat_q;
    logic             pend_q;
    logic             inc_apply;

    assign inc_apply = inc && !we_rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
            stat_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (we_wptr) wptr_q <= wd_ptr;
            if (we_rptr)        rptr_q <= wd_ptr;
            else if (inc_apply) rptr_q <= rptr_q + PTR_W'(1);
            if (we_stat)
                stat_q <= qstat_t'(merge_masked(stat_q,
                                                wd_stat[STAT_W-1:0],
                                                wd_stat[2*STAT_W-1:SEN_LSB]));
            if (inc_apply && imask) pend_q <= 1'b1;
            else if (clr_pend)      pend_q <= 1'b0;
        end
    end

    always_comb begin
        view.wptr = wptr_q;
        view.rptr = rptr_q;
        view.stat = stat_q;
        view.pend = pend_q;
    end

    // R6: an applied increment advances the pointer by one, wrapping
    p_rptr_step_r6: assert property (@(posedge clk) disable iff (rst)
        (inc && !we_rptr) |=> view.rptr == $past(view.rptr) + PTR_W'(1));

    // R7: software value wins over a simultaneous increment
    p_sw_wins_r7: assert property (@(posedge clk) disable iff (rst)
        we_rptr |=> view.rptr == $past(wd_ptr));

    // R8: a status write with no enable bits leaves the word alone
    p_stat_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (we_stat && wd_stat[2*STAT_W-1:SEN_LSB] == '0) |=> $stable(view.stat));

    // R9: an enabled, applied increment sets the pending bit
    p_pend_set_r9: assert property (@(posedge clk) disable iff (rst)
        (inc && !we_rptr && imask) |=> view.pend);

    // R10: pending is sticky until cleared
    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (view.pend && !clr_pend) |=> view.pend);

endmodule

// File: rtl/sched_csr_rdmux.sv
module sched_csr_rdmux
    import sched_csr_pkg::*;
(
    input  dec_t                 dec,
    input  logic [NQ-1:0]        empty_flags,
    input  logic [NCH-1:0]       chan_en,
    input  logic [NQ-1:0]        chain_sel,
    input  logic [NQ-1:0]        irq_en,
    input  logic [NQ-1:0]        pend_vec,
    input  qview_t [NQ-1:0]      qv,
    output logic [DATA_W-1:0]    rdata
);

    always_comb begin
        rdata = '0;
        case (dec.rg)
            RG_EMPTY: rdata[NQ-1:0]     = empty_flags;
            RG_CHAN:  rdata[NCH-1:0]    = chan_en;
            RG_CHAIN: rdata[NQ-1:0]     = chain_sel;
            RG_IMASK: rdata[NQ-1:0]     = irq_en;
            RG_IPEND: rdata[NQ-1:0]     = pend_vec;
            RG_WPTR:  rdata[PTR_W-1:0]  = qv[dec.q].wptr;
            RG_RPTR:  rdata[PTR_W-1:0]  = qv[dec.q].rptr;
            RG_STAT:  rdata[STAT_W-1:0] = qv[dec.q].stat;
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/sched_csr.sv
module sched_csr
    import sched_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NQ-1:0]     sched_rp_inc,
    output logic              irq
);

    dec_t            dec;
    logic            we_empty, we_chan, we_chain, we_imask, we_ipend;
    logic [NQ-1:0]   we_wptr, we_rptr, we_stat;
    logic [NQ-1:0]   empty_flags;
    logic [NCH-1:0]  chan_en;
    logic [NQ-1:0]   chain_sel;
    logic [NQ-1:0]   irq_en;
    logic [NQ-1:0]   clr_pend;
    logic [NQ-1:0]   pend_vec;
    qview_t [NQ-1:0] qv;

    sched_csr_decode u_decode (
        .addr     (reg_addr),
        .wen      (reg_wen),
        .dec      (dec),
        .we_empty (we_empty),
        .we_chan  (we_chan),
        .we_chain (we_chain),
        .we_imask (we_imask),
        .we_ipend (we_ipend),
        .we_wptr  (we_wptr),
        .we_rptr  (we_rptr),
        .we_stat  (we_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            empty_flags <= '0;
            chan_en     <= '0;
            chain_sel   <= '0;
            irq_en      <= '0;
        end else begin
            if (we_empty)
                empty_flags <= (empty_flags & ~reg_wdata[EMASK_LSB+NQ-1:EMASK_LSB])
                             | (reg_wdata[NQ-1:0] & reg_wdata[EMASK_LSB+NQ-1:EMASK_LSB]);
            if (we_chan)  chan_en   <= reg_wdata[NCH-1:0];
            if (we_chain) chain_sel <= reg_wdata[NQ-1:0];
            if (we_imask) irq_en    <= reg_wdata[NQ-1:0];
        end
    end

    assign clr_pend = we_ipend ? reg_wdata[NQ-1:0] : '0;

    for (genvar q = 0; q < NQ; q++) begin : g_slot
        sched_csr_qslot u_slot (
            .clk      (clk),
            .rst      (rst),
            .we_wptr  (we_wptr[q]),
            .we_rptr  (we_rptr[q]),
            .we_stat  (we_stat[q]),
            .wd_ptr   (reg_wdata[PTR_W-1:0]),
            .wd_stat  (reg_wdata[2*STAT_W-1:0]),
            .inc      (sched_rp_inc[q]),
            .imask    (irq_en[q]),
            .clr_pend (clr_pend[q]),
            .view     (qv[q])
        );
        assign pend_vec[q] = qv[q].pend;
    end

    sched_csr_rdmux u_rdmux (
        .dec         (dec),
        .empty_flags (empty_flags),
        .chan_en     (chan_en),
        .chain_sel   (chain_sel),
        .irq_en      (irq_en),
        .pend_vec    (pend_vec),
        .qv          (qv),
        .rdata       (reg_rdata)
    );

    assign irq = |pend_vec;

    // R12: one write reaches at most one target
    p_one_target_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({we_empty, we_chan, we_chain, we_imask, we_ipend,
                  we_wptr, we_rptr, we_stat}));

    // R2: an all-zero mask leaves the empty flags untouched
    p_empty_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (we_empty && reg_wdata[EMASK_LSB+NQ-1:EMASK_LSB] == '0) |=> $stable(empty_flags));

    // R4: reserved upper half reads zero
    p_resv_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (dec.rg == RG_CHAIN || dec.rg == RG_IMASK) |-> reg_rdata[DATA_W-1:NQ] == '0);

    // R1: registers start from zero after reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && empty_flags == '0 && irq_en == '0));

endmodule

// File: tb/sched_csr_tb_top.sv
`timescale 1ns/1ps
module sched_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] sched_rp_inc = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sched_csr dut_i (
        .clk          (clk),
        .rst          (rst),
        .reg_wen      (reg_wen),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .sched_rp_inc (sched_rp_inc),
        .irq          (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_inc(input logic [15:0] vec);
        @(negedge clk);
        sched_rp_inc = vec;
        @(negedge clk);
        sched_rp_inc = '0;
    endtask

    task automatic wr_with_inc(input logic [7:0] a, input logic [31:0] d, input logic [15:0] vec);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d; sched_rp_inc = vec;
        @(negedge clk);
        reg_wen = 1'b0; sched_rp_inc = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        rd_chk("R1 empty", 8'h00, 0);
        rd_chk("R1 chan", 8'h04, 0);
        rd_chk("R1 chain", 8'h08, 0);
        rd_chk("R1 imask", 8'h0C, 0);
        rd_chk("R1 pend", 8'h10, 0);
        rd_chk("R1 wptr", 8'h40, 0);
        rd_chk("R1 rptr", 8'hBC, 0);
        rd_chk("R1 stat", 8'hC0, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_empty();
        wr(8'h00, 32'h0000_FFFF);
        rd_chk("R2 zero mask", 8'h00, 32'h0000_0000);
        wr(8'h00, 32'h00FF_FFFF);
        rd_chk("R2 low byte", 8'h00, 32'h0000_00FF);
        wr(8'h00, 32'hFF0F_0005);
        rd_chk("R2 partial mask", 8'h00, 32'h0000_00F5);
    endtask

    task automatic t_chan();
        wr(8'h04, 32'hFFFF_FFA5);
        rd_chk("R3 chan enable", 8'h04, 32'h0000_00A5);
    endtask

    task automatic t_chain_imask();
        wr(8'h08, 32'hABCD_1234);
        rd_chk("R4 chain", 8'h08, 32'h0000_1234);
        wr(8'h0C, 32'h5678_8001);
        rd_chk("R4 imask", 8'h0C, 32'h0000_8001);
        wr(8'h0C, 32'h0);
    endtask

    task automatic t_wptr();
        for (int q = 0; q < 16; q++)
            wr(8'(8'h40 + 4*q), 32'hA5A5_A500 | 32'(q*16 + 3));
        for (int q = 0; q < 16; q++)
            rd_chk("R5 wptr", 8'(8'h40 + 4*q), 32'(q*16 + 3));
        rd_chk("R5 rptr untouched", 8'h84, 0);
    endtask

    task automatic t_rptr();
        wr(8'h8C, 32'hFFFF_FFFE);
        rd_chk("R6 rptr write", 8'h8C, 32'hFE);
        pulse_inc(16'h0008);
        rd_chk("R6 rptr inc", 8'h8C, 32'hFF);
        pulse_inc(16'h0008);
        rd_chk("R6 rptr wrap", 8'h8C, 32'h00);
        pulse_inc(16'h8001);
        rd_chk("R6 multi q0", 8'h80, 32'h01);
        rd_chk("R6 multi q15", 8'hBC, 32'h01);
        rd_chk("R9 no pend when disabled", 8'h10, 0);
        chk("R11 irq low", {31'd0, irq}, 0);
    endtask

    task automatic t_collide();
        wr(8'h0C, 32'h0000_FFFF);
        wr_with_inc(8'h94, 32'h40, 16'h0020);
        rd_chk("R7 sw wins", 8'h94, 32'h40);
        rd_chk("R7 no pend", 8'h10, 0);
    endtask

    task automatic t_irq();
        wr(8'h0C, 32'h0000_0004);
        pulse_inc(16'h0004);
        chk("R11 irq high", {31'd0, irq}, 1);
        rd_chk("R9 pend set", 8'h10, 32'h4);
        pulse_inc(16'h0040);
        rd_chk("R9 disabled q6", 8'h10, 32'h4);
    endtask

    task automatic t_w1c();
        wr(8'h10, 32'h0);
        rd_chk("R10 write 0 keeps", 8'h10, 32'h4);
        wr(8'h10, 32'h4);
        rd_chk("R10 w1c", 8'h10, 0);
        chk("R11 irq cleared", {31'd0, irq}, 0);
        wr_with_inc(8'h10, 32'h4, 16'h0004);
        rd_chk("R10 set beats clear", 8'h10, 32'h4);
        chk("R11 irq after race", {31'd0, irq}, 1);
        wr(8'h10, 32'hFFFF);
    endtask

    task automatic t_status();
        wr(8'hDC, 32'h000F_FD2B);
        rd_chk("R8 full write", 8'hDC, 32'h12B);
        wr(8'hDC, 32'h0000_780E);
        rd_chk("R8 fifo field only", 8'hDC, 32'h12F);
        wr(8'hDC, 32'hFFF0_03FF);
        rd_chk("R8 no enables", 8'hDC, 32'h12F);
        rd_chk("R8 neighbour", 8'hD8, 0);
    endtask

    task automatic t_unmapped();
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R12 unmapped read", 8'h14, 0);
        rd_chk("R12 unmapped 3C", 8'h3C, 0);
        wr(8'h01, 32'hFFFF_FFFF);
        rd_chk("R12 misaligned write ignored", 8'h00, 32'h0000_00F5);
        rd_chk("R12 misaligned read", 8'h41, 0);
    endtask

    initial begin
        t_reset();
        t_empty();
        t_chan();
        t_chain_imask();
        t_wptr();
        t_rptr();
        t_collide();
        t_irq();
        t_w1c();
        t_status();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule